// File: doc/BRIEF.md
# Multi-Source Reset and Start-Up Sequencer

This block merges every reset request of a chip into a single held chip-reset signal. It also records which kind of event caused the most recent reset or wake-up. The requests are a power-on pulse, an active-low external reset pin, a watchdog time-out and a brown-out detect with its own enable. A sleep flag decides whether a pin or watchdog event counts as a sleep event or a run event. A watchdog time-out that arrives in sleep is a wake-up, not a reset: the block raises a one-cycle wake pulse and leaves the chip reset low.

The external pin is synchronised and then filtered, so short low pulses never reach the reset logic. When the chip reset is released, two delay counters keep it high for longer. The power-up counter advances on ticks of a separate internal RC clock. The start-up counter advances on ticks of the main oscillator. Both clocks arrive as tick-enable strobes in the fabric clock domain.

Software reads two status bits (time-out and power-down), a brown-out flag and a 3-bit cause code to learn which reset happened.

Top module: `rst_seq_top`

## Requirements
- R1: The cause code takes one of six values: 0 power-on, 1 pin reset in run, 2 pin reset in sleep, 3 watchdog reset in run, 4 watchdog wake in sleep, 5 brown-out. When several events arrive in the same cycle, the priority is power-on, then brown-out, then pin, then watchdog.
- R2: A watchdog rising edge while sleep_i is high gives a wake_o pulse of exactly one cycle, in the cycle after the edge is sampled. It does not assert chip_rst_o.
- R3: The pin reset is accepted only after the synchronised pin has been low for FILT_LEN (4) consecutive RC ticks. The synchroniser has two stages. A low pulse of 3 cycles has no effect on chip_rst_o or on the cause code.
- R4: A watchdog rising edge while sleep_i is low asserts chip_rst_o in the cycle after it is sampled.
- R5: brow-out input bor_i causes nothing while bor_en_i is low. It causes a brown-out reset only when bor_en_i is high.
- R6: After a power-on or brown-out request ends, the chip reset stays high through 1024 RC ticks and then 1024 oscillator ticks. With one-cycle requests and ticks on every cycle, chip_rst_o is high for 2049 cycles.
- R7: After a pin or watchdog reset, only the start-up counter runs. With one-cycle requests and ticks on every cycle, chip_rst_o is high for 1025 cycles.
- R8: When pwrt_en_i is low, the power-up phase is skipped. When ost_en_i is low, the start-up phase is skipped. With both phases skipped, the reset lasts 1 cycle.
- R9: The status bits {to_o, pd_o} become 1,1 on power-on and brown-out, 0,1 on a watchdog reset in run, 0,0 on a watchdog wake, and 1,0 on a pin reset in sleep. A pin reset in run leaves both bits unchanged.
- R10: bor_flag_o is set by a brown-out, cleared by a power-on, and unchanged by every other event.
- R11: The chip reset stays high while a level request (pin low after filtering, brown-out high, power-on high) is active. A new reset event during the release sequence restarts the sequence from the beginning.
- R12: The fabric reset rst acts as a power-on. It sets chip_rst_o high, {to_o, pd_o} to 1,1, the cause to 0 and bor_flag_o to 0, and the full power-on sequence follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high fabric reset, treated as power-on |
| por_i | input | 1 | Power-on request |
| pin_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| wdt_to_i | input | 1 | Watchdog time-out |
| bor_i | input | 1 | Brown-out detect |
| bor_en_i | input | 1 | Brown-out reset enable |
| sleep_i | input | 1 | Chip is in sleep mode |
| pwrt_en_i | input | 1 | Enable the power-up delay phase |
| ost_en_i | input | 1 | Enable the oscillator start-up phase |
| rc_tick_i | input | 1 | Tick strobe of the internal RC clock |
| osc_tick_i | input | 1 | Tick strobe of the main oscillator |
| chip_rst_o | output | 1 | Held chip reset |
| wake_o | output | 1 | One-cycle wake-up pulse |
| to_o | output | 1 | Time-out status bit |
| pd_o | output | 1 | Power-down status bit |
| bor_flag_o | output | 1 | Brown-out occurred flag |
| cause_o | output | 3 | Encoded cause of the last reset or wake |

## Verification
Each reset source is applied alone, in both run and sleep state, so that the cause code and status pair can be compared for each of the six events. A run pin reset that follows a watchdog reset shows that the status bits are left unchanged. Reset lengths are measured under each combination of timer enables, which separates the power-on path from the shorter path. Other patterns test the filter and the source priority: a 3-cycle pin glitch against a long low level, a brown-out with and without its enable, a brown-out coinciding with a watchdog edge, and a watchdog edge in the middle of a sequence.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [2:0] {
    CAUSE_POR       = 3'd0,
    CAUSE_PIN_RUN   = 3'd1,
    CAUSE_PIN_SLEEP = 3'd2,
    CAUSE_WDT_RUN   = 3'd3,
    CAUSE_WDT_WAKE  = 3'd4,
    CAUSE_BROWNOUT  = 3'd5
  } cause_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_HOLD  = 2'd1,
    PH_PWRUP = 2'd2,
    PH_OSCST = 2'd3
  } phase_e;

  localparam int NUM_TIMERS = 2;
  localparam int TMR_PWRUP  = 0;
  localparam int TMR_OSCST  = 1;

endpackage

// File: rtl/rst_pin_filter.sv
module rst_pin_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n_i,
  input  logic tick_i,
  output logic req_o
);

  localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   req_q;
  logic                   pin_low;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n_i};
  end

  assign pin_low = ~sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else if (!pin_low) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else if (tick_i && !req_q) begin
      if (cnt_q == LAST) req_q <= 1'b1;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign req_o = req_q;

endmodule

// File: rtl/rst_delay_timer.sv
module rst_delay_timer #(
  parameter int CNT_W = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic tick_i,
  output logic done_o
);

  localparam logic [CNT_W-1:0] TERM = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i)  cnt_q <= '0;
    else if (tick_i)    cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && tick_i && (cnt_q == TERM);

endmodule

// File: rtl/rst_cause_tracker.sv
module rst_cause_tracker
  import rst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       por_i,
  input  logic       pin_req_i,
  input  logic       wdt_i,
  input  logic       bor_req_i,
  input  logic       sleep_i,
  output logic       rst_evt_o,
  output logic       full_seq_o,
  output logic       wake_o,
  output logic       to_o,
  output logic       pd_o,
  output logic       bor_flag_o,
  output logic [2:0] cause_o
);

  logic   pin_prev_q, wdt_prev_q, bor_prev_q;
  logic   pin_evt, wdt_evt, bor_evt;
  logic   to_q, pd_q, flag_q, wake_q;
  cause_e cause_q;

  assign pin_evt = pin_req_i & ~pin_prev_q;
  assign wdt_evt = wdt_i     & ~wdt_prev_q;
  assign bor_evt = bor_req_i & ~bor_prev_q;

  assign full_seq_o = por_i | bor_evt;
  assign rst_evt_o  = por_i | bor_evt | pin_evt | (wdt_evt & ~sleep_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_prev_q <= 1'b0;
      wdt_prev_q <= 1'b0;
      bor_prev_q <= 1'b0;
    end else begin
      pin_prev_q <= pin_req_i;
      wdt_prev_q <= wdt_i;
      bor_prev_q <= bor_req_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      to_q    <= 1'b1;
      pd_q    <= 1'b1;
      flag_q  <= 1'b0;
      wake_q  <= 1'b0;
      cause_q <= CAUSE_POR;
    end else begin
      wake_q <= 1'b0;
      if (por_i) begin
        to_q    <= 1'b1;
        pd_q    <= 1'b1;
        flag_q  <= 1'b0;
        cause_q <= CAUSE_POR;
      end else if (bor_evt) begin
        to_q    <= 1'b1;
        pd_q    <= 1'b1;
        flag_q  <= 1'b1;
        cause_q <= CAUSE_BROWNOUT;
      end else if (pin_evt) begin
        if (sleep_i) begin
          to_q    <= 1'b1;
          pd_q    <= 1'b0;
          cause_q <= CAUSE_PIN_SLEEP;
        end else begin
          cause_q <= CAUSE_PIN_RUN;
        end
      end else if (wdt_evt) begin
        to_q <= 1'b0;
        if (sleep_i) begin
          pd_q    <= 1'b0;
          wake_q  <= 1'b1;
          cause_q <= CAUSE_WDT_WAKE;
        end else begin
          pd_q    <= 1'b1;
          cause_q <= CAUSE_WDT_RUN;
        end
      end
    end
  end

  assign wake_o     = wake_q;
  assign to_o       = to_q;
  assign pd_o       = pd_q;
  assign bor_flag_o = flag_q;
  assign cause_o    = cause_q;

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rst_evt_i,
  input  logic full_i,
  input  logic hold_i,
  input  logic pwrt_en_i,
  input  logic ost_en_i,
  input  logic pwrt_done_i,
  input  logic ost_done_i,
  output logic chip_rst_o,
  output logic pwrt_run_o,
  output logic ost_run_o
);

  phase_e phase_q, phase_d;
  logic   full_q;

  always_comb begin
    phase_d = phase_q;
    if (rst_evt_i) begin
      phase_d = PH_HOLD;
    end else if (phase_q != PH_IDLE && hold_i) begin
      phase_d = PH_HOLD;
    end else begin
      unique case (phase_q)
        PH_HOLD: begin
          if (full_q && pwrt_en_i) phase_d = PH_PWRUP;
          else if (ost_en_i)       phase_d = PH_OSCST;
          else                     phase_d = PH_IDLE;
        end
        PH_PWRUP: begin
          if (pwrt_done_i) phase_d = ost_en_i ? PH_OSCST : PH_IDLE;
        end
        PH_OSCST: begin
          if (ost_done_i) phase_d = PH_IDLE;
        end
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_HOLD;
      full_q  <= 1'b1;
    end else begin
      phase_q <= phase_d;
      if (rst_evt_i) full_q <= full_i;
    end
  end

  assign chip_rst_o = (phase_q != PH_IDLE);
  assign pwrt_run_o = (phase_q == PH_PWRUP);
  assign ost_run_o  = (phase_q == PH_OSCST);

endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
  import rst_seq_pkg::*;
#(
  parameter int TMR_W       = 10,
  parameter int FILT_LEN    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       por_i,
  input  logic       pin_rst_n_i,
  input  logic       wdt_to_i,
  input  logic       bor_i,
  input  logic       bor_en_i,
  input  logic       sleep_i,
  input  logic       pwrt_en_i,
  input  logic       ost_en_i,
  input  logic       rc_tick_i,
  input  logic       osc_tick_i,
  output logic       chip_rst_o,
  output logic       wake_o,
  output logic       to_o,
  output logic       pd_o,
  output logic       bor_flag_o,
  output logic [2:0] cause_o
);

  logic pin_req, bor_req, hold_lvl;
  logic rst_evt, full_seq;
  logic pwrt_run, ost_run;
  logic [NUM_TIMERS-1:0] tmr_run, tmr_tick, tmr_done;

  rst_pin_filter #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_LEN   (FILT_LEN)
  ) u_filter (
    .clk    (clk),
    .rst    (rst),
    .pin_n_i(pin_rst_n_i),
    .tick_i (rc_tick_i),
    .req_o  (pin_req)
  );

  assign bor_req  = bor_i & bor_en_i;
  assign hold_lvl = por_i | pin_req | bor_req;

  rst_cause_tracker u_cause (
    .clk       (clk),
    .rst       (rst),
    .por_i     (por_i),
    .pin_req_i (pin_req),
    .wdt_i     (wdt_to_i),
    .bor_req_i (bor_req),
    .sleep_i   (sleep_i),
    .rst_evt_o (rst_evt),
    .full_seq_o(full_seq),
    .wake_o    (wake_o),
    .to_o      (to_o),
    .pd_o      (pd_o),
    .bor_flag_o(bor_flag_o),
    .cause_o   (cause_o)
  );

  rst_seq_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .rst_evt_i  (rst_evt),
    .full_i     (full_seq),
    .hold_i     (hold_lvl),
    .pwrt_en_i  (pwrt_en_i),
    .ost_en_i   (ost_en_i),
    .pwrt_done_i(tmr_done[TMR_PWRUP]),
    .ost_done_i (tmr_done[TMR_OSCST]),
    .chip_rst_o (chip_rst_o),
    .pwrt_run_o (pwrt_run),
    .ost_run_o  (ost_run)
  );

  assign tmr_run[TMR_PWRUP]  = pwrt_run;
  assign tmr_run[TMR_OSCST]  = ost_run;
  assign tmr_tick[TMR_PWRUP] = rc_tick_i;
  assign tmr_tick[TMR_OSCST] = osc_tick_i;

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_tmr
    rst_delay_timer #(.CNT_W(TMR_W)) u_tmr (
      .clk   (clk),
      .rst   (rst),
      .run_i (tmr_run[g]),
      .tick_i(tmr_tick[g]),
      .done_o(tmr_done[g])
    );
  end

endmodule

// File: rtl/rst_seq_checker.sv
module rst_seq_checker
  import rst_seq_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       por_i,
  input logic       wdt_to_i,
  input logic       sleep_i,
  input logic       bor_en_i,
  input logic       chip_rst_o,
  input logic       wake_o,
  input logic       to_o,
  input logic       pd_o,
  input logic       bor_flag_o,
  input logic [2:0] cause_o
);

  AST_CAUSE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    cause_o <= 3'd5); // R1

  AST_WAKE_NO_RESET: assert property (@(posedge clk) disable iff (rst)
    (wake_o && !$past(chip_rst_o)) |-> !chip_rst_o); // R2

  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wake_o |=> !wake_o); // R2

  AST_WDT_RUN_RESET: assert property (@(posedge clk) disable iff (rst)
    ($past(wdt_to_i) && !$past(wdt_to_i, 2) && !$past(sleep_i)) |-> chip_rst_o); // R4

  AST_BOR_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(bor_flag_o) |-> $past(bor_en_i)); // R5

  AST_WAKE_STATUS: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> (!to_o && !pd_o && cause_o == CAUSE_WDT_WAKE)); // R9

  AST_POR_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $past(por_i) |-> (chip_rst_o && to_o && pd_o && !bor_flag_o && cause_o == CAUSE_POR)); // R10

endmodule

bind rst_seq_top rst_seq_checker u_chk (.*);

// File: tb/rst_seq_top_tb_top.sv
module rst_seq_top_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       por_i = 1'b0, pin_rst_n_i = 1'b1, wdt_to_i = 1'b0;
  logic       bor_i = 1'b0, bor_en_i = 1'b0, sleep_i = 1'b0;
  logic       pwrt_en_i = 1'b1, ost_en_i = 1'b1;
  logic       rc_tick_i = 1'b1, osc_tick_i = 1'b1;
  logic       chip_rst_o, wake_o, to_o, pd_o, bor_flag_o;
  logic [2:0] cause_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  rst_seq_top dut_i (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_range(input string tag, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic measure(output int n);
    n = 0;
    while (chip_rst_o && n < 6000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic pulse_wdt();
    @(negedge clk) wdt_to_i = 1'b1;
    @(negedge clk) wdt_to_i = 1'b0;
  endtask

  task automatic test_reset_state();
    int n;
    repeat (3) @(negedge clk);
    chk("R12 chip_rst in reset", chip_rst_o, 1);
    chk("R12 status in reset", {to_o, pd_o}, 3);
    chk("R12 cause in reset", cause_o, 0);
    chk("R12 bor flag in reset", bor_flag_o, 0);
    rst = 1'b0;
    measure(n);
    chk("R6 R12 power-on length", n, 2049);
  endtask

  task automatic test_wdt_run();
    int n;
    pulse_wdt();
    chk("R4 chip_rst after wdt", chip_rst_o, 1);
    chk("R9 status wdt run", {to_o, pd_o}, 1);
    chk("R1 cause wdt run", cause_o, 3);
    measure(n);
    chk("R7 wdt reset length", n, 1025);
  endtask

  task automatic test_pin_run();
    int n;
    @(negedge clk) pin_rst_n_i = 1'b0;
    repeat (12) @(negedge clk);
    chk("R3 long low accepted", chip_rst_o, 1);
    chk("R1 cause pin run", cause_o, 1);
    chk("R9 pin run keeps status", {to_o, pd_o}, 1);
    repeat (20) @(negedge clk);
    chk("R11 held while pin low", chip_rst_o, 1);
    pin_rst_n_i = 1'b1;
    measure(n);
    chk_range("R11 R7 release after pin", n, 1025, 1032);
  endtask

  task automatic test_glitch();
    int seen = 0;
    @(negedge clk) pin_rst_n_i = 1'b0;
    repeat (3) @(negedge clk);
    pin_rst_n_i = 1'b1;
    for (int i = 0; i < 15; i++) begin
      if (chip_rst_o) seen = 1;
      @(negedge clk);
    end
    chk("R3 glitch ignored", seen, 0);
    chk("R3 cause unchanged by glitch", cause_o, 1);
  endtask

  task automatic test_wdt_sleep();
    @(negedge clk) sleep_i = 1'b1;
    pulse_wdt();
    chk("R2 wake pulse", wake_o, 1);
    chk("R2 no chip reset on wake", chip_rst_o, 0);
    chk("R9 status wake", {to_o, pd_o}, 0);
    chk("R1 cause wake", cause_o, 4);
    @(negedge clk);
    chk("R2 wake one cycle", wake_o, 0);
    chk("R2 still no chip reset", chip_rst_o, 0);
  endtask

  task automatic test_pin_sleep();
    int n;
    @(negedge clk) pin_rst_n_i = 1'b0;
    repeat (12) @(negedge clk);
    chk("R1 cause pin sleep", cause_o, 2);
    chk("R9 status pin sleep", {to_o, pd_o}, 2);
    pin_rst_n_i = 1'b1;
    sleep_i = 1'b0;
    measure(n);
    chk_range("R7 release after pin sleep", n, 1025, 1032);
  endtask

  task automatic test_bor_gate();
    int seen = 0;
    @(negedge clk) begin bor_en_i = 1'b0; bor_i = 1'b1; end
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (chip_rst_o) seen = 1;
    end
    bor_i = 1'b0;
    chk("R5 disabled brown-out ignored", seen, 0);
    chk("R5 flag stays clear", bor_flag_o, 0);
    chk("R5 cause unchanged", cause_o, 2);
  endtask

  task automatic test_bor();
    int n;
    @(negedge clk) begin bor_en_i = 1'b1; bor_i = 1'b1; end
    @(negedge clk) bor_i = 1'b0;
    chk("R1 cause brown-out", cause_o, 5);
    chk("R10 brown-out flag set", bor_flag_o, 1);
    chk("R9 status brown-out", {to_o, pd_o}, 3);
    measure(n);
    chk("R6 brown-out length", n, 2049);
  endtask

  task automatic test_no_ost();
    int n;
    ost_en_i = 1'b0;
    pulse_wdt();
    chk("R10 flag kept by wdt", bor_flag_o, 1);
    measure(n);
    chk("R8 both phases skipped", n, 1);
    ost_en_i = 1'b1;
  endtask

  task automatic test_por_no_pwrt();
    int n;
    pwrt_en_i = 1'b0;
    @(negedge clk) por_i = 1'b1;
    @(negedge clk) por_i = 1'b0;
    chk("R10 power-on clears flag", bor_flag_o, 0);
    chk("R9 status power-on", {to_o, pd_o}, 3);
    chk("R1 cause power-on", cause_o, 0);
    measure(n);
    chk("R8 power-up phase skipped", n, 1025);
    pwrt_en_i = 1'b1;
  endtask

  task automatic test_priority();
    int n;
    @(negedge clk) begin wdt_to_i = 1'b1; bor_i = 1'b1; end
    @(negedge clk) begin wdt_to_i = 1'b0; bor_i = 1'b0; end
    chk("R1 brown-out wins over wdt", cause_o, 5);
    measure(n);
    chk("R6 length with priority", n, 2049);
  endtask

  task automatic test_restart();
    int n;
    pulse_wdt();
    repeat (500) @(negedge clk);
    chk("R11 mid-sequence still held", chip_rst_o, 1);
    pulse_wdt();
    measure(n);
    chk("R11 sequence restarted", n, 1025);
  endtask

  initial begin
    test_reset_state();
    test_wdt_run();
    test_pin_run();
    test_glitch();
    test_wdt_sleep();
    test_pin_sleep();
    test_bor_gate();
    test_bor();
    test_no_ost();
    test_por_no_pwrt();
    test_priority();
    test_restart();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule